// File: doc/BRIEF.md
# Step-Direction to Quadrature Generator

This block rebuilds a two-phase quadrature pair from a single-wire step strobe and a direction bit. It is the output stage after a count-down divider: each accepted step walks a two-bit state one position around a four-entry Gray ring. The two state bits drive the quadrature outputs directly, so exactly one output toggles per step and the pair stays 90 degrees apart.

The step and direction inputs may come from another clock domain or a slow source. Both pass through the same synchronizer chain. A step is then detected as a rising transition against the system clock, so the block never uses the strobe as a clock. A registered copy of the direction used for the most recent step is also presented, in line with the quadrature pair.

Top module: `stepdir_quad_gen`

## Requirements
- R1: While rst_ni is low the outputs are {qa_o,qb_o}=00 and dir_o=0, asynchronously and without waiting for a clock edge.
- R2: With dir_i=1 (forward), successive steps move {qa_o,qb_o} through 10, 11, 01, 00 and back to 10. From 00 a forward step gives 10.
- R3: With dir_i=0 (reverse), successive steps move {qa_o,qb_o} through 00, 01, 11, 10 and back to 00.
- R4: Each step changes exactly one of qa_o and qb_o. The outputs change at no other time.
- R5: A step is one low-to-high transition of step_i as sampled by clk_i. A strobe held high for many cycles counts as a single step. step_i must stay high for at least one clock and low for at least one clock between steps.
- R6: With the default two synchronizer stages, the outputs take their new value on the third rising clk_i edge that samples step_i high, counting that first edge as edge one.
- R7: dir_o equals the dir_i value that came with the most recent step, and it updates on the same edge as the quadrature pair.
- R8: Changes of dir_i with no step have no effect on any output. A reversal takes effect on the next step and moves exactly one ring position, with no state skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Step strobe, level input, rising transition = one step |
| dir_i | input | 1 | Direction for the step, 1 = forward, 0 = reverse |
| qa_o | output | 1 | Quadrature phase A |
| qb_o | output | 1 | Quadrature phase B |
| dir_o | output | 1 | Direction of the most recent step |

## Verification
The outputs are the state, so a wrong next-state entry appears on the pins at the very step that uses it. A two-bit jump, a stuck phase or a wrong ring order is visible three cycles after the offending strobe. An edge detector that re-fires, or that misses a strobe, shows up as an extra or missing phase change against the expected step count. A direction path that is out of alignment with the step path shows up as a wrong ring direction on the first step after a reversal.

// File: rtl/stepdir_quad_pkg.sv
package stepdir_quad_pkg;
  typedef logic [1:0] quad_t;

  localparam quad_t QUAD_RST = 2'b00;

  // one position around the Gray ring; fwd: 10->11->01->00->10
  function automatic quad_t quad_next(input quad_t cur, input logic fwd);
    quad_t nxt;
    unique case (cur)
      2'b10:   nxt = fwd ? 2'b11 : 2'b00;
      2'b11:   nxt = fwd ? 2'b01 : 2'b10;
      2'b01:   nxt = fwd ? 2'b00 : 2'b11;
      default: nxt = fwd ? 2'b10 : 2'b01;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/stepdir_quad_sync.sv
module stepdir_quad_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/stepdir_quad_edge.sv
module stepdir_quad_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R5
endmodule

// File: rtl/stepdir_quad_ring.sv
module stepdir_quad_ring
  import stepdir_quad_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  logic  fwd_i,
  output quad_t ab_o,
  output logic  dir_o
);
  quad_t ab_q;
  logic  dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ab_q  <= QUAD_RST;
      dir_q <= 1'b0;
    end else if (adv_i) begin
      ab_q  <= quad_next(ab_q, fwd_i);
      dir_q <= fwd_i;
    end
  end

  assign ab_o  = ab_q;
  assign dir_o = dir_q;

  AST_ONE_PHASE_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> $countones(ab_q ^ $past(ab_q)) == 1); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ab_q) && $stable(dir_q)); // R8
  AST_FWD_FROM_10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && fwd_i && ab_q == 2'b10) |=> ab_q == 2'b11); // R2
  AST_FWD_FROM_00: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && fwd_i && ab_q == 2'b00) |=> ab_q == 2'b10); // R2
  AST_REV_FROM_00: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !fwd_i && ab_q == 2'b00) |=> ab_q == 2'b01); // R3
  AST_REV_FROM_10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !fwd_i && ab_q == 2'b10) |=> ab_q == 2'b00); // R3
  AST_DIR_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> dir_q == $past(fwd_i)); // R7
endmodule

// File: rtl/stepdir_quad_gen.sv
module stepdir_quad_gen
  import stepdir_quad_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic dir_i,
  output logic qa_o,
  output logic qb_o,
  output logic dir_o
);
  localparam int SyncW = 2;

  logic [SyncW-1:0] raw_in, syn_out;
  logic             step_rise;
  quad_t            ab;

  assign raw_in = {dir_i, step_i};

  // step and direction share one chain so they stay aligned
  stepdir_quad_sync #(.WIDTH(SyncW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_out)
  );

  stepdir_quad_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (syn_out[0]),
    .rise_o(step_rise)
  );

  stepdir_quad_ring u_ring (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (step_rise),
    .fwd_i (syn_out[1]),
    .ab_o  (ab),
    .dir_o (dir_o)
  );

  assign qa_o = ab[1];
  assign qb_o = ab[0];

  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> {qa_o, qb_o, dir_o} == 3'b000); // R1
endmodule

// File: tb/stepdir_quad_gen_tb_top.sv
module stepdir_quad_gen_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic step_i = 1'b0;
  logic dir_i = 1'b0;
  logic qa_o, qb_o, dir_o;

  always #5 clk = ~clk;

  stepdir_quad_gen dut_i (
    .clk_i (clk), .rst_ni(rst_ni), .step_i(step_i), .dir_i(dir_i),
    .qa_o  (qa_o), .qb_o(qb_o), .dir_o(dir_o)
  );

  typedef struct {
    logic [1:0] ab;
    logic       dir;
    int         cyc;
  } exp_t;

  exp_t       exp_q[$];
  int         checks = 0;
  int         failures = 0;
  int         cyc = 0;
  logic [1:0] model_ab = 2'b00;
  logic [1:0] last_ab = 2'b00;
  bit         mon_en = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] ring(input logic [1:0] c, input logic f);
    if (f) return (c == 2'b10) ? 2'b11 : (c == 2'b11) ? 2'b01 : (c == 2'b01) ? 2'b00 : 2'b10;
    return (c == 2'b00) ? 2'b01 : (c == 2'b01) ? 2'b11 : (c == 2'b11) ? 2'b10 : 2'b00;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: one strobe, high for hi cycles then low for lo cycles
  task automatic do_step(input logic d, input int hi, input int lo);
    exp_t e;
    @(negedge clk);
    dir_i  = d;
    step_i = 1'b1;
    model_ab = ring(model_ab, d);
    e.ab = model_ab; e.dir = d; e.cyc = cyc + 3;
    exp_q.push_back(e);
    repeat (hi) @(negedge clk);
    step_i = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  // monitor: every phase change must match the head of the queue
  always @(negedge clk) begin
    logic [1:0] cur;
    exp_t e;
    cur = {qa_o, qb_o};
    if (mon_en && cur != last_ab) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "phase change with no step", int'(cur), int'(last_ab));
      end else begin
        e = exp_q.pop_front();
        chk(cur == e.ab, e.dir ? "R2" : "R3", "ring position", int'(cur), int'(e.ab));
        chk($countones(cur ^ last_ab) == 1, "R4", "bits changed",
            $countones(cur ^ last_ab), 1);
        chk(dir_o == e.dir, "R7", "dir_o", int'(dir_o), int'(e.dir));
        chk(cyc == e.cyc, "R6", "update cycle", cyc, e.cyc);
      end
    end
    last_ab = cur;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic settle_and_match(input string req);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, req, "pending steps", exp_q.size(), 0);
    chk({qa_o, qb_o} == model_ab, req, "quad state", int'({qa_o, qb_o}), int'(model_ab));
  endtask

  initial begin
    #3;
    chk({qa_o, qb_o, dir_o} == 3'b000, "R1", "reset outputs", int'({qa_o, qb_o, dir_o}), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;

    // R2 forward full turn plus one, minimum spacing
    for (int i = 0; i < 5; i++) do_step(1'b1, 1, 1);
    settle_and_match("R2");
    // R3 reverse full turn
    for (int i = 0; i < 4; i++) do_step(1'b0, 2, 3);
    settle_and_match("R3");
    // R8 reversals every step, no skipped state
    for (int i = 0; i < 6; i++) do_step(i[0], 1, 2);
    settle_and_match("R8");
    // R5 strobe held high long counts once
    do_step(1'b1, 12, 4);
    settle_and_match("R5");
    // R8 direction wiggles without a step
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      dir_i = ~dir_i;
    end
    settle_and_match("R8");
    chk(dir_o == 1'b1, "R8", "dir_o after wiggle", int'(dir_o), 1);
    // R7 direction output follows a reverse step
    do_step(1'b0, 1, 1);
    settle_and_match("R7");

    // R1 asynchronous reset in mid-run
    do_step(1'b1, 1, 1);
    settle_and_match("R2");
    mon_en = 1'b0;
    @(negedge clk);
    #2 rst_ni = 1'b0;
    #1 chk({qa_o, qb_o, dir_o} == 3'b000, "R1", "async reset", int'({qa_o, qb_o, dir_o}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    model_ab = 2'b00;
    exp_q.delete();
    @(negedge clk);
    mon_en = 1'b1;
    do_step(1'b1, 1, 1);
    settle_and_match("R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule